// File: doc/BRIEF.md
# Big-Number Engine Host Register Block

This block is the host-visible control and status register bank of a big-number arithmetic engine. A host drives a simple single-cycle register bus with 32-bit accesses. Through it the host programs four operand word pointers, two operand word counts and a shift amount, and starts an operation through the function register. The block hands the datapath a one-cycle start pulse, a stable snapshot of the operands and the selected operation. The datapath answers with a done pulse that carries a compare code and two most-significant-word reports. The block then publishes those results and drops its run indication.

The pointer and length registers are double buffered. The host may stage the operands for the next operation while the current one is still using its snapshot. The shift amount and the operation bits are locked while an operation runs. A stall bit in the function register lets the host keep reading the previous results: while it is set, a finished operation holds its results back and stays "running". A small sequencer control register carries host-to-sequencer request flags, which only the host sets and only the sequencer clears. It also holds a sequencer hold bit, and a read-only word gives an identification signature.

Top module: `bignum_host_regs`

## Requirements
- R1: After reset the function register reads 0 apart from the visible run bit, the result registers read 0, the request flags are 0 and the sequencer hold bit (bit 31 of the sequencer control word) reads 1.
- R2: The word addresses are: 0 to 3 for pointers A to D (11 bits), 4 and 5 for lengths A and B (9 bits), 6 for the shift (5 bits), 7 for function, 8 for compare (3 bits), 9 for result MSW (16 bits), 10 for remainder MSW (16 bits), 11 for sequencer control and 15 for the signature. Writes keep only the field bits, and unused bits read as 0.
- R3: A pointer or length write goes to a staging copy, which reads back at once. The datapath sees the value staged at the most recent start and keeps it for the whole operation. A register that is not written keeps its staged value.
- R4: While an operation runs, host writes to the shift register and to function bits [14:0] are ignored.
- R5: Function bits are [11:0] operation, [14:12] sequencer operation, 15 run and 24 stall. A write with bit 15 set while idle starts an operation. `op_start` pulses for exactly the one cycle after that write, and run reads 1 until completion. `irq_done` is the complement of the visible run bit.
- R6: A start write while an operation runs gives no new start pulse. A done pulse while idle changes no result register.
- R7: With stall at 0, a done pulse updates compare, result MSW and remainder MSW and clears run at the same clock edge.
- R8: With stall at 1, a done pulse leaves the result registers and run unchanged. One cycle after the host writes stall back to 0, the held results are published and run clears.
- R9: Writing 1 to a bit of sequencer control bits [7:0] sets that request flag, and writing 0 leaves it unchanged. `seq_flag_clr` clears flags. A start with nonzero bits [14:12] also sets flag 0.
- R10: Sequencer status input bit 0 (read at bit 8 of sequencer control) at 0 forces the visible run bit to 1 and `irq_done` to 0.
- R11: The signature word reads 0x0000E31C, an ID byte 0x1C and its bitwise complement above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| op_start | output | 1 | One-cycle start pulse to the datapath |
| op_ptrs | output | 44 | Pointer snapshot, pointer i at bits [11i+10:11i] |
| op_lens | output | 18 | Length snapshot, length i at bits [9i+8:9i] |
| op_shift | output | 5 | Shift amount |
| op_func | output | 12 | Basic operation select bits |
| op_seq_sel | output | 3 | Sequencer operation select |
| op_done | input | 1 | Completion pulse from the datapath |
| done_cmp | input | 3 | Compare result code |
| done_msw | input | 16 | Result most-significant-word report |
| done_divmsw | input | 16 | Remainder most-significant-word report |
| seq_status | input | 8 | Sequencer status byte |
| seq_flag_clr | input | 8 | Sequencer clear mask for the request flags |
| seq_flags | output | 8 | Request flags to the sequencer |
| seq_hold | output | 1 | Sequencer hold (reset) |
| irq_done | output | 1 | Completion interrupt, inverse of visible run |

## Verification
The assertions take for granted that the datapath raises `op_done` only as a single-cycle pulse. They also take for granted that the sequencer drives `seq_flag_clr` only when it means to clear flags, since a sticky-flag property is checked only in cycles with no clear. The stimulus follows this. Done pulses are always one cycle long and are driven at the falling edge. The clear mask is pulsed for one cycle only in the flag test. Random operand values come from a fixed seed and cover the full 32-bit write word, so the masking is tested on every field.

// File: rtl/bhr_pkg.sv
`timescale 1ns/1ps
package bhr_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int PTR_W   = 11;
    localparam int LEN_W   = 9;
    localparam int SHIFT_W = 5;
    localparam int NUM_PTR = 4;
    localparam int NUM_LEN = 2;
    localparam int FUNC_W  = 12;
    localparam int SEQ_W   = 3;
    localparam int CMP_W   = 3;
    localparam int MSW_W   = 16;
    localparam int FLAG_W  = 8;

    localparam int SEQ_LSB   = FUNC_W;
    localparam int RUN_BIT   = SEQ_LSB + SEQ_W;
    localparam int STALL_BIT = 24;
    localparam int HOLD_BIT  = DATA_W - 1;

    localparam logic [ADDR_W-1:0] A_PTR0   = 4'd0;
    localparam logic [ADDR_W-1:0] A_LEN0   = 4'd4;
    localparam logic [ADDR_W-1:0] A_SHIFT  = 4'd6;
    localparam logic [ADDR_W-1:0] A_FUNC   = 4'd7;
    localparam logic [ADDR_W-1:0] A_CMP    = 4'd8;
    localparam logic [ADDR_W-1:0] A_MSW    = 4'd9;
    localparam logic [ADDR_W-1:0] A_DIVMSW = 4'd10;
    localparam logic [ADDR_W-1:0] A_SEQCTL = 4'd11;
    localparam logic [ADDR_W-1:0] A_SIG    = 4'd15;

    localparam logic [7:0] SIG_ID = 8'h1C;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic [MSW_W-1:0] msw;
        logic [MSW_W-1:0] divmsw;
    } result_t;
endpackage

// File: rtl/bhr_operand_bank.sv
`timescale 1ns/1ps
module bhr_operand_bank #(
    parameter int N = 4,
    parameter int W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   wr_en,
    input  logic [W-1:0]   wdata,
    input  logic           load,
    output logic [N*W-1:0] staged,
    output logic [N*W-1:0] active
);
    typedef struct packed {
        logic [N-1:0][W-1:0] stage;
        logic [N-1:0][W-1:0] live;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en[i]) bank_d.stage[i] = wdata;
        end
        if (load) bank_d.live = bank_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign staged = bank_q.stage;
    assign active = bank_q.live;
endmodule

// File: rtl/bhr_result_stage.sv
`timescale 1ns/1ps
module bhr_result_stage
    import bhr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    busy,
    input  logic    stall,
    input  logic    done,
    input  result_t res_in,
    output result_t res_pub,
    output logic    finish
);
    typedef struct packed {
        logic    pend;
        result_t held;
        result_t pub;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d   = rs_q;
        finish = 1'b0;
        if (busy && !rs_q.pend && done) begin
            rs_d.pend = 1'b1;
            rs_d.held = res_in;
        end
        if (rs_d.pend && !stall) begin
            rs_d.pub  = rs_d.held;
            rs_d.pend = 1'b0;
            finish    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign res_pub = rs_q.pub;
endmodule

// File: rtl/bhr_seq_flags.sv
`timescale 1ns/1ps
module bhr_seq_flags #(
    parameter int   FW       = 8,
    parameter logic HOLD_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] host_set,
    input  logic          auto_set,
    input  logic [FW-1:0] seq_clr,
    input  logic          hold_we,
    input  logic          hold_val,
    output logic [FW-1:0] flags,
    output logic          hold
);
    localparam logic [FW-1:0] AUTO_MASK = FW'(1);

    typedef struct packed {
        logic [FW-1:0] flags;
        logic          hold;
    } sf_t;

    sf_t sf_d, sf_q;

    always_comb begin
        sf_d       = sf_q;
        sf_d.flags = (sf_q.flags & ~seq_clr) | host_set | (auto_set ? AUTO_MASK : '0);
        if (hold_we) sf_d.hold = hold_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sf_q.flags <= '0;
            sf_q.hold  <= HOLD_RST;
        end else begin
            sf_q <= sf_d;
        end
    end

    assign flags = sf_q.flags;
    assign hold  = sf_q.hold;
endmodule

// File: rtl/bignum_host_regs.sv
`timescale 1ns/1ps
module bignum_host_regs
    import bhr_pkg::*;
#(
    parameter logic PROG_IN_RAM = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_we,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     op_start,
    output logic [NUM_PTR*PTR_W-1:0] op_ptrs,
    output logic [NUM_LEN*LEN_W-1:0] op_lens,
    output logic [SHIFT_W-1:0]       op_shift,
    output logic [FUNC_W-1:0]        op_func,
    output logic [SEQ_W-1:0]         op_seq_sel,
    input  logic                     op_done,
    input  logic [CMP_W-1:0]         done_cmp,
    input  logic [MSW_W-1:0]         done_msw,
    input  logic [MSW_W-1:0]         done_divmsw,
    input  logic [FLAG_W-1:0]        seq_status,
    input  logic [FLAG_W-1:0]        seq_flag_clr,
    output logic [FLAG_W-1:0]        seq_flags,
    output logic                     seq_hold,
    output logic                     irq_done
);
    typedef struct packed {
        logic [FUNC_W-1:0]  func;
        logic [SEQ_W-1:0]   seq_sel;
        logic               stall;
        logic               run;
        logic               start;
        logic [SHIFT_W-1:0] shift;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                     start_req;
    logic                     finish;
    logic                     run_vis;
    logic [NUM_PTR-1:0]       ptr_we;
    logic [NUM_LEN-1:0]       len_we;
    logic [NUM_PTR*PTR_W-1:0] ptr_staged;
    logic [NUM_LEN*LEN_W-1:0] len_staged;
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_rd;
    logic [NUM_LEN-1:0][LEN_W-1:0] len_rd;
    result_t                  res_in, res_pub;
    logic [FLAG_W-1:0]        host_set;
    logic                     seqctl_we;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata[HOLD_BIT-1:STALL_BIT+1], reg_wdata[STALL_BIT-1:RUN_BIT+1]};

    assign start_req = reg_we && (reg_addr == A_FUNC) && reg_wdata[RUN_BIT] && !ctl_q.run;
    assign seqctl_we = reg_we && (reg_addr == A_SEQCTL);
    assign host_set  = seqctl_we ? reg_wdata[FLAG_W-1:0] : '0;

    // Write strobes for the double-buffered operand registers
    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr_we
        assign ptr_we[gi] = reg_we && (reg_addr == A_PTR0 + ADDR_W'(gi));
    end
    for (genvar gj = 0; gj < NUM_LEN; gj++) begin : g_len_we
        assign len_we[gj] = reg_we && (reg_addr == A_LEN0 + ADDR_W'(gj));
    end

    bhr_operand_bank #(.N(NUM_PTR), .W(PTR_W)) i_ptr_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(ptr_we), .wdata(reg_wdata[PTR_W-1:0]),
        .load(start_req), .staged(ptr_staged), .active(op_ptrs)
    );

    bhr_operand_bank #(.N(NUM_LEN), .W(LEN_W)) i_len_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(len_we), .wdata(reg_wdata[LEN_W-1:0]),
        .load(start_req), .staged(len_staged), .active(op_lens)
    );

    assign res_in = '{cmp: done_cmp, msw: done_msw, divmsw: done_divmsw};

    bhr_result_stage i_results (
        .clk(clk), .rst_n(rst_n), .busy(ctl_q.run), .stall(ctl_q.stall),
        .done(op_done), .res_in(res_in), .res_pub(res_pub), .finish(finish)
    );

    bhr_seq_flags #(.FW(FLAG_W), .HOLD_RST(PROG_IN_RAM)) i_seq_flags (
        .clk(clk), .rst_n(rst_n), .host_set(host_set),
        .auto_set(start_req && (reg_wdata[RUN_BIT-1:SEQ_LSB] != '0)),
        .seq_clr(seq_flag_clr), .hold_we(seqctl_we), .hold_val(reg_wdata[HOLD_BIT]),
        .flags(seq_flags), .hold(seq_hold)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        if (reg_we && (reg_addr == A_SHIFT) && !ctl_q.run) begin
            ctl_d.shift = reg_wdata[SHIFT_W-1:0];
        end
        if (reg_we && (reg_addr == A_FUNC)) begin
            ctl_d.stall = reg_wdata[STALL_BIT];
            if (!ctl_q.run) begin
                ctl_d.func    = reg_wdata[FUNC_W-1:0];
                ctl_d.seq_sel = reg_wdata[RUN_BIT-1:SEQ_LSB];
            end
        end
        if (start_req) begin
            ctl_d.run   = 1'b1;
            ctl_d.start = 1'b1;
        end
        if (finish) ctl_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign run_vis    = ctl_q.run | ~seq_status[0];
    assign irq_done   = ~run_vis;
    assign op_start   = ctl_q.start;
    assign op_shift   = ctl_q.shift;
    assign op_func    = ctl_q.func;
    assign op_seq_sel = ctl_q.seq_sel;
    assign ptr_rd     = ptr_staged;
    assign len_rd     = len_staged;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_PTR0, A_PTR0 + 4'd1, A_PTR0 + 4'd2, A_PTR0 + 4'd3:
                reg_rdata = DATA_W'(ptr_rd[reg_addr[1:0]]);
            A_LEN0, A_LEN0 + 4'd1:
                reg_rdata = DATA_W'(len_rd[reg_addr[0]]);
            A_SHIFT:  reg_rdata = DATA_W'(ctl_q.shift);
            A_FUNC: begin
                reg_rdata[FUNC_W-1:0]       = ctl_q.func;
                reg_rdata[RUN_BIT-1:SEQ_LSB] = ctl_q.seq_sel;
                reg_rdata[RUN_BIT]           = run_vis;
                reg_rdata[STALL_BIT]         = ctl_q.stall;
            end
            A_CMP:    reg_rdata = DATA_W'(res_pub.cmp);
            A_MSW:    reg_rdata = DATA_W'(res_pub.msw);
            A_DIVMSW: reg_rdata = DATA_W'(res_pub.divmsw);
            A_SEQCTL: begin
                reg_rdata[FLAG_W-1:0]        = seq_flags;
                reg_rdata[2*FLAG_W-1:FLAG_W] = seq_status;
                reg_rdata[HOLD_BIT]          = seq_hold;
            end
            A_SIG:    reg_rdata = DATA_W'({~SIG_ID, SIG_ID});
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bhr_checker.sv
`timescale 1ns/1ps
module bhr_checker
    import bhr_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     stall,
    input logic                     op_start,
    input logic                     op_done,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic                     reg_we,
    input logic [SHIFT_W-1:0]       op_shift,
    input logic [NUM_PTR*PTR_W-1:0] op_ptrs,
    input result_t                  res_pub,
    input logic [FLAG_W-1:0]        seq_flags,
    input logic [FLAG_W-1:0]        seq_flag_clr,
    input logic [FLAG_W-1:0]        seq_status,
    input logic                     irq_done
);
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    a_r5_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    a_r3_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_ptrs));

    a_r4_shift_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == A_SHIFT) |=> $stable(op_shift));

    a_r6_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_done) |=> $stable(res_pub));

    a_r8_stall_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> busy);

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_flag_clr == '0) |=> ((seq_flags & $past(seq_flags)) == $past(seq_flags)));

    a_r10_status_forces_run: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_status[0] |-> !irq_done);
endmodule

bind bignum_host_regs bhr_checker i_bhr_checker (
    .clk(clk), .rst_n(rst_n), .busy(ctl_q.run), .stall(ctl_q.stall),
    .op_start(op_start), .op_done(op_done), .reg_addr(reg_addr), .reg_we(reg_we),
    .op_shift(op_shift), .op_ptrs(op_ptrs), .res_pub(res_pub),
    .seq_flags(seq_flags), .seq_flag_clr(seq_flag_clr), .seq_status(seq_status),
    .irq_done(irq_done)
);

// File: tb/test_bignum_host_regs.sv
`timescale 1ns/1ps
module test_bignum_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        op_start;
    logic [43:0] op_ptrs;
    logic [17:0] op_lens;
    logic [4:0]  op_shift;
    logic [11:0] op_func;
    logic [2:0]  op_seq_sel;
    logic        op_done = 1'b0;
    logic [2:0]  done_cmp = '0;
    logic [15:0] done_msw = '0;
    logic [15:0] done_divmsw = '0;
    logic [7:0]  seq_status = '0;
    logic [7:0]  seq_flag_clr = '0;
    logic [7:0]  seq_flags;
    logic        seq_hold;
    logic        irq_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bignum_host_regs i_bignum_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_start(op_start),
        .op_ptrs(op_ptrs), .op_lens(op_lens), .op_shift(op_shift), .op_func(op_func),
        .op_seq_sel(op_seq_sel), .op_done(op_done), .done_cmp(done_cmp),
        .done_msw(done_msw), .done_divmsw(done_divmsw), .seq_status(seq_status),
        .seq_flag_clr(seq_flag_clr), .seq_flags(seq_flags), .seq_hold(seq_hold),
        .irq_done(irq_done)
    );

    function automatic logic [31:0] mask_bits(input logic [31:0] v, input int w);
        return v & ((32'h1 << w) - 32'h1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic done_pulse(input logic [2:0] c, input logic [15:0] m, input logic [15:0] dm);
        op_done = 1'b1; done_cmp = c; done_msw = m; done_divmsw = dm;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL R5 watchdog actual=hang expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] rp [4];
        logic [31:0] rl [2];
        logic [31:0] rs;
        logic [2:0]  ec;
        logic [15:0] em, ed;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10: reset state, status bit 0 low forces visible run
        rd(4'd7, v);  chk("R1 func reset", v, 32'h0000_8000);
        chk("R10 irq low while status bit clear", irq_done, 1'b0);
        rd(4'd11, v); chk("R1 seqctl reset", v, 32'h8000_0000);
        rd(4'd8, v);  chk("R1 cmp reset", v, 0);
        rd(4'd9, v);  chk("R1 msw reset", v, 0);
        rd(4'd15, v); chk("R11 signature", v, 32'h0000_E31C);
        seq_status = 8'h01;
        #1;
        chk("R10 irq high once status set", irq_done, 1'b1);
        rd(4'd7, v);  chk("R10 run clear once status set", v, 32'h0);

        // R2: field masking
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R2 ptr mask", v, 32'h7FF);
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, v); chk("R2 len mask", v, 32'h1FF);
        wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, v); chk("R2 shift mask", v, 32'h1F);

        // R5 / R7: simple start and completion
        wr(4'd0, 32'h100); wr(4'd1, 32'h0AA); wr(4'd6, 32'd3);
        wr(4'd7, 32'h0000_8010);
        chk("R5 start pulse", op_start, 1'b1);
        chk("R3 snapshot ptr A", op_ptrs[10:0], 11'h100);
        chk("R5 irq low while running", irq_done, 1'b0);
        rd(4'd7, v); chk("R5 run visible", v, 32'h0000_8010);
        done_pulse(3'b100, 16'h0123, 16'h8000);
        chk("R5 start pulse one cycle", op_start, 1'b0);
        rd(4'd7, v); chk("R7 run cleared", v, 32'h0000_0010);
        chk("R5 irq high after done", irq_done, 1'b1);
        rd(4'd8, v);  chk("R7 cmp", v, 32'h4);
        rd(4'd9, v);  chk("R7 msw", v, 32'h0123);
        rd(4'd10, v); chk("R7 divmsw", v, 32'h8000);

        // R6: done while idle ignored
        done_pulse(3'b001, 16'h7777, 16'h1111);
        rd(4'd8, v);  chk("R6 idle done cmp", v, 32'h4);
        rd(4'd9, v);  chk("R6 idle done msw", v, 32'h0123);

        // R8 / R3 / R4 / R6: stalled operation
        wr(4'd7, 32'h0100_8020);
        chk("R8 start with stall", op_start, 1'b1);
        wr(4'd0, 32'h200);
        chk("R3 active ptr kept", op_ptrs[10:0], 11'h100);
        rd(4'd0, v); chk("R3 staged readback", v, 32'h200);
        wr(4'd6, 32'd9); rd(4'd6, v); chk("R4 shift locked", v, 32'd3);
        wr(4'd7, 32'h0100_8FFF);
        chk("R6 no restart pulse", op_start, 1'b0);
        rd(4'd7, v); chk("R4 func locked", v, 32'h0100_8020);
        done_pulse(3'b010, 16'h0044, 16'h0005);
        rd(4'd7, v); chk("R8 run held by stall", v[15], 1'b1);
        rd(4'd8, v); chk("R8 cmp held", v, 32'h4);
        wr(4'd7, 32'h0000_0000);
        rd(4'd8, v); chk("R8 not yet published", v, 32'h4);
        @(negedge clk);
        rd(4'd8, v); chk("R8 cmp published", v, 32'h2);
        rd(4'd9, v); chk("R8 msw published", v, 32'h0044);
        rd(4'd7, v); chk("R8 run cleared", v, 32'h0000_0020);

        wr(4'd7, 32'h0000_8001);
        chk("R3 new ptr A used", op_ptrs[10:0], 11'h200);
        chk("R3 unwritten ptr B kept", op_ptrs[21:11], 11'h0AA);
        done_pulse(3'b001, 16'h0, 16'h0);

        // R9: request flags
        wr(4'd11, 32'h0000_0005);
        chk("R9 flags set", seq_flags, 8'h05);
        chk("R9 hold cleared", seq_hold, 1'b0);
        wr(4'd11, 32'h0000_0000);
        chk("R9 zero write keeps flags", seq_flags, 8'h05);
        seq_flag_clr = 8'h05;
        @(negedge clk);
        seq_flag_clr = 8'h00;
        chk("R9 sequencer clear", seq_flags, 8'h00);
        wr(4'd7, 32'h0000_B000);
        chk("R9 auto flag on sequencer start", seq_flags, 8'h01);
        chk("R5 sequencer select", op_seq_sel, 3'd3);
        done_pulse(3'b0, 16'h0, 16'h0);

        // Random operand and result patterns
        for (int it = 0; it < 24; it++) begin
            for (int k = 0; k < 4; k++) begin
                rp[k] = $urandom;
                wr(4'(k), rp[k]);
            end
            for (int k = 0; k < 2; k++) begin
                rl[k] = $urandom;
                wr(4'(4 + k), rl[k]);
            end
            rs = $urandom;
            wr(4'd6, rs);
            rd(4'd2, v); chk("R2 random ptr C readback", v, mask_bits(rp[2], 11));
            rd(4'd4, v); chk("R2 random len A readback", v, mask_bits(rl[0], 9));
            wr(4'd7, 32'h0000_8000 | ($urandom & 32'hFFF));
            chk("R5 random start", op_start, 1'b1);
            chk("R3 random ptr snapshot", op_ptrs,
                {mask_bits(rp[3],11)[10:0], mask_bits(rp[2],11)[10:0],
                 mask_bits(rp[1],11)[10:0], mask_bits(rp[0],11)[10:0]});
            chk("R3 random len snapshot", op_lens,
                {mask_bits(rl[1],9)[8:0], mask_bits(rl[0],9)[8:0]});
            chk("R2 random shift", op_shift, rs[4:0]);
            ec = 3'($urandom); em = 16'($urandom); ed = 16'($urandom);
            done_pulse(ec, em, ed);
            rd(4'd8, v);  chk("R7 random cmp", v, 32'(ec));
            rd(4'd9, v);  chk("R7 random msw", v, 32'(em));
            rd(4'd10, v); chk("R7 random divmsw", v, 32'(ed));
            chk("R5 random irq", irq_done, 1'b1);
        end

        finish_run();
    end
endmodule